// File: doc/BRIEF.md
# Serial Infrared Pulse Codec

This block sits between a UART framer and an infrared transceiver. On the transmit side it turns the framer's NRZ bit stream into short light pulses: a zero bit becomes one pulse and a one bit leaves the emitter dark. The pulse width comes from one of two sources. The first is a fixed share of the bit period, measured in 16x baud ticks. The second is a fixed count of ticks from a separate reference that does not depend on the bit rate, which saves emitter power. On the receive side it takes the active-low detector signal, synchronises it, and stretches each detected pulse into a full zero bit for the framer.

The infrared path is used only when the UART and the infrared function are both enabled. While it is in use, the ordinary wired transmit line is held at the marking level and the wired receive line is ignored. An internal test path can loop the emitter drive, inverted, back into the detector input. A second loop path ties the wired transmit line to the receive output.

Top module: `sir_codec`

## Requirements
- R1: While the infrared path is inactive (`uart_en_i` or `sir_en_i` low), `ir_tx_o` is 0 from the next clock on, whatever the transmit data.
- R2: While the infrared path is active, `txd_o` is 1; while it is inactive, `txd_o` equals `tx_nrz_i`.
- R3: In fraction mode (`lowpwr_i` = 0), a bit period is 16 baud ticks, numbered 0 to 15 from the first tick after activation. The bit is sampled at tick 0. A zero bit raises `ir_tx_o` (1 = light) on tick 7, the eighth tick, and lowers it on tick 10, so the pulse lasts 3/16 of the bit.
- R4: A one bit produces no pulse anywhere in its bit period.
- R5: In reference mode (`lowpwr_i` = 1), a zero-bit pulse starts on tick 7 and ends on the third `lp_tick_i` after it starts. Baud ticks in between neither shorten nor extend it.
- R6: `ir_rx_ni` is active low (0 = light). It passes through two synchroniser flops and is sampled on baud ticks. A sample showing light drives `rx_nrz_o` to 0, and `rx_nrz_o` returns to 1 on the 16th following baud tick that sees no light. A pulse that no tick samples has no effect.
- R7: While the infrared path is active, `uart_rxd_i` has no effect on `rx_nrz_o`.
- R8: While the infrared path is inactive, `ir_rx_ni` has no effect and `rx_nrz_o` follows the wired receive source.
- R9: With `uart_en_i` low, `sir_en_i` has no effect: the emitter stays dark, `txd_o` follows `tx_nrz_i` and `rx_nrz_o` follows `uart_rxd_i`.
- R10: With `loopback_i` and `sir_test_i` both 1 while active, the decoder input is the inverted emitter drive and `ir_rx_ni` is ignored.
- R11: With `loopback_i` = 1 and `sir_test_i` = 0 while inactive, `rx_nrz_o` equals `tx_nrz_i`.
- R12: Deactivating the infrared path resets the bit phase, so the first baud tick after reactivation is tick 0 of a new bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| uart_en_i | input | 1 | Overall UART enable |
| sir_en_i | input | 1 | Infrared path enable |
| lowpwr_i | input | 1 | 1 = pulse width from reference ticks |
| loopback_i | input | 1 | Loopback request |
| sir_test_i | input | 1 | With loopback, selects the infrared loop |
| baud16_tick_i | input | 1 | One-cycle strobe at 16x the bit rate |
| lp_tick_i | input | 1 | One-cycle strobe of the low-power reference |
| tx_nrz_i | input | 1 | NRZ transmit bit from the framer |
| uart_rxd_i | input | 1 | Wired receive line |
| ir_rx_ni | input | 1 | Detector input, 0 = light |
| ir_tx_o | output | 1 | Emitter drive, 1 = light |
| txd_o | output | 1 | Wired transmit line |
| rx_nrz_o | output | 1 | NRZ receive bit to the framer |

## Verification
The bench builds the codec with its default parameters: 16 ticks per bit, pulse start at tick 7, a three-tick pulse, a three-tick reference pulse and two synchroniser stages. Baud ticks arrive every second cycle, so a whole bit takes 32 cycles. This makes every tick edge of both pulse shapes observable, together with the exact 16-tick release of the receive stretcher. Because the reference ticks are issued independently of the baud ticks, the bench can make a reference-mode pulse either outlast several baud ticks or end before the next one.

// File: rtl/sir_pkg.sv
package sir_pkg;
  typedef enum logic {
    PW_FRACTION = 1'b0,
    PW_REFCLK   = 1'b1
  } pw_mode_e;
endpackage

// File: rtl/sir_bit_phase.sv
module sir_bit_phase #(
  parameter  int unsigned TICKS_PER_BIT = 16,
  localparam int unsigned PH_W          = $clog2(TICKS_PER_BIT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            tick_i,
  output logic [PH_W-1:0] phase_o
);
  localparam logic [PH_W-1:0] LAST = PH_W'(TICKS_PER_BIT - 1);

  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (!active_i) begin
      phase_d = '0;
    end else if (tick_i) begin
      phase_d = (phase_q == LAST) ? '0 : phase_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  assign phase_o = phase_q;

  assert_phase_clear_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> (phase_q == '0));
  assert_phase_hold_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !tick_i) |=> $stable(phase_q));
endmodule

// File: rtl/sir_pulse_enc.sv
module sir_pulse_enc import sir_pkg::*; #(
  parameter  int unsigned TICKS_PER_BIT  = 16,
  parameter  int unsigned PULSE_START    = 7,
  parameter  int unsigned PULSE_TICKS    = 3,
  parameter  int unsigned LP_PULSE_TICKS = 3,
  localparam int unsigned PH_W           = $clog2(TICKS_PER_BIT)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            active_i,
  input  logic            lowpwr_i,
  input  logic            baud_tick_i,
  input  logic            lp_tick_i,
  input  logic            tx_bit_i,
  input  logic [PH_W-1:0] phase_i,
  output logic            ir_o
);
  localparam int unsigned     LP_W     = $clog2(LP_PULSE_TICKS + 1);
  localparam logic [PH_W-1:0] P_FIRST  = PH_W'(PULSE_START);
  localparam logic [PH_W-1:0] P_LAST   = PH_W'(PULSE_START + PULSE_TICKS - 1);
  localparam logic [LP_W-1:0] LP_LOAD  = LP_W'(LP_PULSE_TICKS);

  pw_mode_e        mode;
  logic            bit_q, bit_d;
  logic            out_q, out_d;
  logic [LP_W-1:0] lp_q, lp_d;
  logic            in_window, start_hit;

  assign mode      = pw_mode_e'(lowpwr_i);
  assign in_window = (phase_i >= P_FIRST) && (phase_i <= P_LAST);
  assign start_hit = baud_tick_i && (phase_i == P_FIRST) && !bit_q;

  always_comb begin
    bit_d = bit_q;
    out_d = out_q;
    lp_d  = lp_q;
    if (!active_i) begin
      bit_d = 1'b1;
      out_d = 1'b0;
      lp_d  = '0;
    end else begin
      if (baud_tick_i && (phase_i == '0)) bit_d = tx_bit_i;
      if (mode == PW_FRACTION) begin
        lp_d = '0;
        if (baud_tick_i) out_d = in_window && !bit_q;
      end else begin
        if (start_hit) begin
          out_d = 1'b1;
          lp_d  = LP_LOAD;
        end else if (lp_q == '0) begin
          out_d = 1'b0;
        end else if (lp_tick_i) begin
          lp_d = lp_q - 1'b1;
          if (lp_q == LP_W'(1)) out_d = 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q <= 1'b1;
      out_q <= 1'b0;
      lp_q  <= '0;
    end else begin
      bit_q <= bit_d;
      out_q <= out_d;
      lp_q  <= lp_d;
    end
  end

  assign ir_o = out_q;

  assert_dark_when_off_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> !out_q);
  assert_rise_needs_low_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_q) |-> $past(baud_tick_i && !bit_q));
  assert_fraction_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !lowpwr_i && !baud_tick_i) |=> $stable(out_q));
  assert_ref_fall_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(out_q) && $past(active_i) && $past(lowpwr_i)) |-> $past(lp_tick_i || (lp_q == '0)));
endmodule

// File: rtl/sir_pulse_dec.sv
module sir_pulse_dec #(
  parameter int unsigned TICKS_PER_BIT = 16,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic active_i,
  input  logic baud_tick_i,
  input  logic ir_n_i,
  output logic rx_bit_o
);
  localparam int unsigned     CW   = $clog2(TICKS_PER_BIT + 1);
  localparam logic [CW-1:0]   HOLD = CW'(TICKS_PER_BIT);

  logic [SYNC_STAGES-1:0] sync_q, sync_d;
  logic [CW-1:0]          cnt_q, cnt_d;
  logic                   seen;

  assign seen = !sync_q[SYNC_STAGES-1];

  always_comb begin
    sync_d = {sync_q[SYNC_STAGES-2:0], ir_n_i};
    cnt_d  = cnt_q;
    if (!active_i) begin
      cnt_d = '0;
    end else if (baud_tick_i) begin
      if (seen)              cnt_d = HOLD;
      else if (cnt_q != '0)  cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '1;
      cnt_q  <= '0;
    end else begin
      sync_q <= sync_d;
      cnt_q  <= cnt_d;
    end
  end

  assign rx_bit_o = (cnt_q == '0);

  assert_rx_idle_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_i |=> rx_bit_o);
  assert_rx_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i && !baud_tick_i) |=> $stable(rx_bit_o));
  assert_rx_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rx_bit_o) |-> $past(baud_tick_i && seen));
endmodule

// File: rtl/sir_codec.sv
module sir_codec #(
  parameter int unsigned TICKS_PER_BIT  = 16,
  parameter int unsigned PULSE_START    = 7,
  parameter int unsigned PULSE_TICKS    = 3,
  parameter int unsigned LP_PULSE_TICKS = 3,
  parameter int unsigned SYNC_STAGES    = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic uart_en_i,
  input  logic sir_en_i,
  input  logic lowpwr_i,
  input  logic loopback_i,
  input  logic sir_test_i,
  input  logic baud16_tick_i,
  input  logic lp_tick_i,
  input  logic tx_nrz_i,
  input  logic uart_rxd_i,
  input  logic ir_rx_ni,
  output logic ir_tx_o,
  output logic txd_o,
  output logic rx_nrz_o
);
  localparam int unsigned PH_W = $clog2(TICKS_PER_BIT);

  logic [1:0]      rst_sync_q;
  logic            rst_n;
  logic            sir_active, ir_loop, wire_loop;
  logic            ir_drive, dec_src, dec_rx;
  logic [PH_W-1:0] phase;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= '0;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  assign sir_active = uart_en_i && sir_en_i;
  assign ir_loop    = loopback_i && sir_test_i;
  assign wire_loop  = loopback_i && !sir_test_i;
  assign dec_src    = ir_loop ? !ir_drive : ir_rx_ni;

  sir_bit_phase #(.TICKS_PER_BIT(TICKS_PER_BIT)) phase_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .active_i (sir_active),
    .tick_i   (baud16_tick_i),
    .phase_o  (phase)
  );

  sir_pulse_enc #(
    .TICKS_PER_BIT  (TICKS_PER_BIT),
    .PULSE_START    (PULSE_START),
    .PULSE_TICKS    (PULSE_TICKS),
    .LP_PULSE_TICKS (LP_PULSE_TICKS)
  ) enc_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .active_i    (sir_active),
    .lowpwr_i    (lowpwr_i),
    .baud_tick_i (baud16_tick_i),
    .lp_tick_i   (lp_tick_i),
    .tx_bit_i    (tx_nrz_i),
    .phase_i     (phase),
    .ir_o        (ir_drive)
  );

  sir_pulse_dec #(
    .TICKS_PER_BIT (TICKS_PER_BIT),
    .SYNC_STAGES   (SYNC_STAGES)
  ) dec_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_n),
    .active_i    (sir_active),
    .baud_tick_i (baud16_tick_i),
    .ir_n_i      (dec_src),
    .rx_bit_o    (dec_rx)
  );

  assign ir_tx_o  = ir_drive;
  assign txd_o    = sir_active ? 1'b1 : tx_nrz_i;
  assign rx_nrz_o = sir_active ? dec_rx : (wire_loop ? tx_nrz_i : uart_rxd_i);

  assert_txd_mark_R2: assert property (@(posedge clk_i) disable iff (!rst_n)
    sir_active |-> txd_o);
  assert_uart_off_dark_R9: assert property (@(posedge clk_i) disable iff (!rst_n)
    !uart_en_i |=> !ir_tx_o);
endmodule

// File: tb/sir_codec_tb_top.sv
`timescale 1ns/1ps
module sir_codec_tb_top;
  logic clk = 1'b0;
  logic rst_n, uart_en, sir_en, lowpwr, loopback, sir_test;
  logic baud, lp, tx_nrz, uart_rxd, ir_in;
  logic ir_tx, txd, rx_nrz;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #2 clk = ~clk;

  sir_codec dut_i (
    .clk_i(clk), .rst_ni(rst_n), .uart_en_i(uart_en), .sir_en_i(sir_en),
    .lowpwr_i(lowpwr), .loopback_i(loopback), .sir_test_i(sir_test),
    .baud16_tick_i(baud), .lp_tick_i(lp), .tx_nrz_i(tx_nrz),
    .uart_rxd_i(uart_rxd), .ir_rx_ni(ir_in),
    .ir_tx_o(ir_tx), .txd_o(txd), .rx_nrz_o(rx_nrz)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic btick();
    baud = 1'b1; @(negedge clk); baud = 1'b0; @(negedge clk);
  endtask

  task automatic ltick();
    lp = 1'b1; @(negedge clk); lp = 1'b0; @(negedge clk);
  endtask

  task automatic restart(input logic lpw, input logic lb, input logic st);
    sir_en = 1'b0; cyc(2);
    lowpwr = lpw; loopback = lb; sir_test = st;
    uart_en = 1'b1; sir_en = 1'b1;
  endtask

  task automatic send_bit(input logic b, input bit check_ir);
    tx_nrz = b;
    for (int k = 0; k < 16; k++) begin
      btick();
      if (check_ir)
        chk(b ? "R4 high bit dark" : "R3 pulse ticks 7..9", ir_tx,
            (!b && k >= 7 && k <= 9));
    end
  endtask

  task automatic t_reset();
    chk("R1 reset emitter dark", ir_tx, 1'b0);
    chk("R2 inactive txd follows data", txd, 1'b0);
    chk("R8 inactive rx follows wire", rx_nrz, 1'b1);
  endtask

  task automatic t_fraction();
    restart(1'b0, 1'b0, 1'b0);
    send_bit(1'b0, 1);
    chk("R2 txd marks while active", txd, 1'b1);
    send_bit(1'b1, 1);
    send_bit(1'b0, 1);
    tx_nrz = 1'b0;
    for (int k = 0; k < 5; k++) btick();
    sir_en = 1'b0;
    for (int k = 0; k < 6; k++) begin
      btick();
      chk("R1 inactive dark", ir_tx, 1'b0);
    end
    sir_en = 1'b1;
    for (int k = 0; k < 16; k++) begin
      btick();
      chk("R12 phase restarts", ir_tx, (k >= 7 && k <= 9));
    end
  endtask

  task automatic t_refmode();
    restart(1'b1, 1'b0, 1'b0);
    tx_nrz = 1'b0;
    for (int k = 0; k < 7; k++) begin btick(); chk("R5 dark before start", ir_tx, 1'b0); end
    btick();  chk("R5 start tick 7", ir_tx, 1'b1);
    ltick();  chk("R5 after ref 1", ir_tx, 1'b1);
    btick();  chk("R5 baud tick 8", ir_tx, 1'b1);
    ltick();  chk("R5 after ref 2", ir_tx, 1'b1);
    for (int k = 9; k < 12; k++) begin btick(); chk("R5 baud ticks ignored", ir_tx, 1'b1); end
    ltick();  chk("R5 end on ref 3", ir_tx, 1'b0);
    for (int k = 12; k < 16; k++) btick();
    for (int k = 0; k < 8; k++) btick();
    chk("R5 second start", ir_tx, 1'b1);
    ltick(); ltick(); chk("R5 still lit", ir_tx, 1'b1);
    ltick(); chk("R5 short end", ir_tx, 1'b0);
    for (int k = 8; k < 16; k++) begin btick(); chk("R5 dark rest", ir_tx, 1'b0); end
  endtask

  task automatic t_decode();
    restart(1'b0, 1'b0, 1'b0);
    tx_nrz = 1'b1; cyc(3);
    chk("R6 idle high", rx_nrz, 1'b1);
    ir_in = 1'b0; cyc(2);
    baud = 1'b1; ir_in = 1'b1; @(negedge clk); baud = 1'b0; @(negedge clk);
    chk("R6 low after sampled pulse", rx_nrz, 1'b0);
    for (int i = 1; i < 16; i++) begin btick(); chk("R6 held low", rx_nrz, 1'b0); end
    btick(); chk("R6 released on 16th tick", rx_nrz, 1'b1);
    ir_in = 1'b0; cyc(1); ir_in = 1'b1; cyc(2);
    for (int i = 0; i < 4; i++) begin btick(); chk("R6 unsampled pulse ignored", rx_nrz, 1'b1); end
  endtask

  task automatic t_bypass();
    sir_en = 1'b0; uart_rxd = 1'b0; cyc(1);
    chk("R8 rx follows wire low", rx_nrz, 1'b0);
    uart_rxd = 1'b1; ir_in = 1'b0;
    for (int i = 0; i < 4; i++) btick();
    chk("R8 detector ignored", rx_nrz, 1'b1);
    ir_in = 1'b1;
    restart(1'b0, 1'b0, 1'b0); cyc(3);
    uart_rxd = 1'b0; cyc(1);
    chk("R7 wire ignored", rx_nrz, 1'b1);
    btick(); btick();
    chk("R7 wire still ignored", rx_nrz, 1'b1);
    uart_rxd = 1'b1;
  endtask

  task automatic t_uart_off();
    sir_en = 1'b0; cyc(1); uart_en = 1'b0; sir_en = 1'b1; tx_nrz = 1'b0;
    for (int k = 0; k < 16; k++) begin btick(); chk("R9 dark with uart off", ir_tx, 1'b0); end
    chk("R9 txd follows data", txd, 1'b0);
    uart_rxd = 1'b0; cyc(1);
    chk("R9 rx follows wire", rx_nrz, 1'b0);
    uart_rxd = 1'b1; uart_en = 1'b1;
  endtask

  task automatic t_ir_loop();
    restart(1'b0, 1'b1, 1'b1);
    ir_in = 1'b0;
    send_bit(1'b1, 0); send_bit(1'b1, 0);
    chk("R10 external light ignored", rx_nrz, 1'b1);
    send_bit(1'b0, 0);
    chk("R10 looped pulse decoded", rx_nrz, 1'b0);
    send_bit(1'b1, 0);
    chk("R10 looped one decoded", rx_nrz, 1'b1);
    ir_in = 1'b1;
  endtask

  task automatic t_wire_loop();
    sir_en = 1'b0; loopback = 1'b1; sir_test = 1'b0;
    uart_rxd = 1'b1; tx_nrz = 1'b0; cyc(1);
    chk("R11 rx equals tx low", rx_nrz, 1'b0);
    tx_nrz = 1'b1; uart_rxd = 1'b0; cyc(1);
    chk("R11 rx equals tx high", rx_nrz, 1'b1);
  endtask

  initial begin
    rst_n = 1'b0; uart_en = 1'b0; sir_en = 1'b0; lowpwr = 1'b0;
    loopback = 1'b0; sir_test = 1'b0; baud = 1'b0; lp = 1'b0;
    tx_nrz = 1'b0; uart_rxd = 1'b1; ir_in = 1'b1;
    cyc(3); rst_n = 1'b1; cyc(4);
    t_reset();
    t_fraction();
    t_refmode();
    t_decode();
    t_bypass();
    t_uart_off();
    t_ir_loop();
    t_wire_loop();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run did not complete, all requirements unverified");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule